// File: doc/BRIEF.md
# Jabber, Heartbeat and Collision-Presence Controller

This block is the digital control core of a coaxial-cable transceiver. It watches a qualified transmit-activity flag, the output of a collision comparator and a heartbeat-enable strap. From these it decides two things: whether the line transmitter must be shut off, and whether a free-running 10 MHz source is gated onto the collision-presence pair.

Three conditions turn the collision-presence output on:
- A collision is being reported.
- A short heartbeat window is open. It opens a fixed delay after each transmission ends, so the attached station knows the collision path works.
- The transmitter is locked out after an over-long transmission (jabber).

The lockout is held in a latch. The latch releases only after the transmit input has stayed silent for an unbroken quiet interval, and any activity restarts that interval. Every duration is a parameter counted in system-clock ticks. The defaults suit a 200 MHz clock: 40 ms jabber limit, 0.5 s quiet interval, 1.1 µs heartbeat delay and 1 µs heartbeat width.

Top module: `jab_hb_ctrl`

## Requirements
- R1: While rst_ni is low, tx_disable_o and cp_en_o are 0 with all other inputs at 0. No heartbeat window or lockout survives a reset.
- R2: When tx_valid_i has been sampled high on JAB_TICKS consecutive clock edges, tx_disable_o goes to 1 after the last of those edges.
- R3: While tx_disable_o is 1, cp_en_o is 1 whatever coll_det_i and hb_en_i are.
- R4: Once locked, tx_disable_o returns to 0 after tx_valid_i has been sampled low on UNJAB_TICKS consecutive edges. Any edge with tx_valid_i high restarts that count.
- R5: A transmission end is an edge with tx_valid_i low where the previous edge sampled it high. If lockout is off and hb_en_i is 1 at that edge, cp_en_o is 1 for HB_WIDTH_TICKS cycles beginning HB_DELAY_TICKS edges later. A newer transmission end restarts the delay.
- R6: A transmission end sampled with hb_en_i at 0 opens no window, and hb_en_i at 0 blanks a window already open.
- R7: A transmission end sampled while tx_disable_o is 1 opens no heartbeat window.
- R8: cp_en_o is 1 in any cycle in which coll_det_i is 1, with no added latency.
- R9: cp_o equals osc_i when cp_en_o is 1 and is 0 when cp_en_o is 0.
- R10: A run of tx_valid_i shorter than JAB_TICKS edges, broken by a single low sample, restarts the jabber count and does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_valid_i | input | 1 | Qualified transmit activity, already squelched |
| coll_det_i | input | 1 | Collision comparator output |
| hb_en_i | input | 1 | Heartbeat enable strap, 1 = enabled |
| osc_i | input | 1 | 10 MHz source to be gated |
| tx_disable_o | output | 1 | Transmitter shut-off, 1 while locked out |
| cp_en_o | output | 1 | Collision-presence driver enable; 0 = zero-differential idle |
| cp_o | output | 1 | Gated 10 MHz collision-presence signal |

## Verification
The assertions assume that tx_valid_i, coll_det_i and hb_en_i are synchronous to clk_i, that a lock can arise only from sampled activity, and that an unlock can arise only from a sampled quiet edge. The bench drives every input on the falling edge, so each value is stable across the rising edge that samples it. It uses small tick counts and shapes its bursts to land just below and well above the jabber limit. It also breaks the quiet interval with a single active cycle, ends a transmission while locked, toggles the strap during an open window, and applies reset in the middle of a heartbeat delay.

// File: rtl/jab_hb_pkg.sv
package jab_hb_pkg;

  typedef enum logic {
    JAB_OPEN,
    JAB_LOCKED
  } jab_state_e;

  typedef enum logic [1:0] {
    HB_IDLE,
    HB_WAIT,
    HB_PULSE
  } hb_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/jab_timer.sv
module jab_timer
  import jab_hb_pkg::*;
#(
  parameter int unsigned JAB_TICKS   = 8_000_000,
  parameter int unsigned UNJAB_TICKS = 100_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  output logic locked_o
);

  localparam int unsigned CNT_MAX = max_u(JAB_TICKS, UNJAB_TICKS);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] JAB_LAST   = CNT_W'(JAB_TICKS - 1);
  localparam logic [CNT_W-1:0] UNJAB_LAST = CNT_W'(UNJAB_TICKS - 1);

  jab_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // one counter serves both phases: active run while open, quiet run while locked
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      JAB_OPEN: begin
        if (!tx_valid_i) begin
          cnt_d = '0;
        end else if (cnt_q == JAB_LAST) begin
          state_d = JAB_LOCKED;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      JAB_LOCKED: begin
        if (tx_valid_i) begin
          cnt_d = '0;
        end else if (cnt_q == UNJAB_LAST) begin
          state_d = JAB_OPEN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: begin
        state_d = JAB_OPEN;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= JAB_OPEN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign locked_o = (state_q == JAB_LOCKED);

  p_lock_on_activity_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(tx_valid_i));

  p_unlock_on_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> !$past(tx_valid_i));

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o ? (cnt_q <= UNJAB_LAST) : (cnt_q <= JAB_LAST)));

endmodule

// File: rtl/hb_timer.sv
module hb_timer
  import jab_hb_pkg::*;
#(
  parameter int unsigned HB_DELAY_TICKS = 220,
  parameter int unsigned HB_WIDTH_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  input  logic hb_en_i,
  input  logic locked_i,
  output logic hb_win_o
);

  localparam int unsigned HB_MAX = max_u(HB_DELAY_TICKS, HB_WIDTH_TICKS);
  localparam int unsigned HB_W   = $clog2(HB_MAX + 1);
  localparam logic [HB_W-1:0] DLY_LAST = HB_W'(HB_DELAY_TICKS - 1);
  localparam logic [HB_W-1:0] WID_LAST = HB_W'(HB_WIDTH_TICKS - 1);

  hb_state_e       state_q, state_d;
  logic [HB_W-1:0] cnt_q, cnt_d;
  logic            tx_q;
  logic            tx_end;
  logic            start;

  assign tx_end = tx_q & ~tx_valid_i;
  // no SQE test after a lockout-truncated frame or with the strap off
  assign start  = tx_end & hb_en_i & ~locked_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (start) begin
      state_d = HB_WAIT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        HB_IDLE: cnt_d = '0;
        HB_WAIT: begin
          if (cnt_q == DLY_LAST) begin
            state_d = HB_PULSE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + HB_W'(1);
          end
        end
        HB_PULSE: begin
          if (cnt_q == WID_LAST) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + HB_W'(1);
          end
        end
        default: begin
          state_d = HB_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HB_IDLE;
      cnt_q   <= '0;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tx_q    <= tx_valid_i;
    end
  end

  assign hb_win_o = (state_q == HB_PULSE) & hb_en_i;

  p_no_start_blocked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HB_IDLE && tx_q && !tx_valid_i && (locked_i || !hb_en_i))
      |=> state_q == HB_IDLE);

  p_pulse_after_wait_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HB_PULSE && $past(state_q) != HB_PULSE) |-> $past(state_q) == HB_WAIT);

endmodule

// File: rtl/cp_select.sv
module cp_select (
  input  logic coll_det_i,
  input  logic hb_win_i,
  input  logic locked_i,
  input  logic osc_i,
  output logic cp_en_o,
  output logic cp_o
);

  assign cp_en_o = coll_det_i | hb_win_i | locked_i;
  assign cp_o    = cp_en_o & osc_i;

endmodule

// File: rtl/jab_hb_ctrl.sv
module jab_hb_ctrl #(
  parameter int unsigned JAB_TICKS      = 8_000_000,
  parameter int unsigned UNJAB_TICKS    = 100_000_000,
  parameter int unsigned HB_DELAY_TICKS = 220,
  parameter int unsigned HB_WIDTH_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_valid_i,
  input  logic coll_det_i,
  input  logic hb_en_i,
  input  logic osc_i,
  output logic tx_disable_o,
  output logic cp_en_o,
  output logic cp_o
);

  logic locked;
  logic hb_win;

  jab_timer #(
    .JAB_TICKS  (JAB_TICKS),
    .UNJAB_TICKS(UNJAB_TICKS)
  ) i_jab_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_valid_i(tx_valid_i),
    .locked_o  (locked)
  );

  hb_timer #(
    .HB_DELAY_TICKS(HB_DELAY_TICKS),
    .HB_WIDTH_TICKS(HB_WIDTH_TICKS)
  ) i_hb_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_valid_i(tx_valid_i),
    .hb_en_i   (hb_en_i),
    .locked_i  (locked),
    .hb_win_o  (hb_win)
  );

  cp_select i_cp_select (
    .coll_det_i(coll_det_i),
    .hb_win_i  (hb_win),
    .locked_i  (locked),
    .osc_i     (osc_i),
    .cp_en_o   (cp_en_o),
    .cp_o      (cp_o)
  );

  assign tx_disable_o = locked;

  p_jab_drives_cp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_disable_o |-> cp_en_o);

  p_coll_drives_cp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_det_i |-> cp_en_o);

  p_cp_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_en_o |-> !cp_o);

endmodule

// File: tb/test_jab_hb_ctrl.sv
`timescale 1ns/1ps
module test_jab_hb_ctrl;

  localparam int J = 20;
  localparam int U = 30;
  localparam int D = 5;
  localparam int W = 4;
  localparam int NONE = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_valid = 1'b0, coll_det = 1'b0, hb_en = 1'b1, osc = 1'b0;
  logic tx_disable, cp_en, cp;

  always #2.5 clk = ~clk;

  jab_hb_ctrl #(
    .JAB_TICKS(J), .UNJAB_TICKS(U), .HB_DELAY_TICKS(D), .HB_WIDTH_TICKS(W)
  ) i_jab_hb_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tx_valid_i(tx_valid), .coll_det_i(coll_det),
    .hb_en_i(hb_en), .osc_i(osc), .tx_disable_o(tx_disable), .cp_en_o(cp_en), .cp_o(cp)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int cyc    = 0;

  // behavioural reference state
  int m_run, m_quiet, m_age, m_cut_age;
  bit m_lock, m_txq;

  task automatic model_reset();
    m_run = 0; m_quiet = 0; m_age = NONE; m_cut_age = NONE; m_lock = 0; m_txq = 0;
  endtask

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit tx, input bit cl, input bit he);
    bit win_raw, win, e_en;
    string tag;
    @(negedge clk);
    cyc++;
    tx_valid = tx; coll_det = cl; hb_en = he; osc = cyc[0];
    #1;
    win_raw = (m_age >= D) && (m_age <= D + W - 1);
    win     = win_raw && he;
    e_en    = cl || win || m_lock;
    if (m_lock) tag = (m_quiet > 0) ? "R4" : "R3";
    else if (win_raw && !he) tag = "R6";
    else if (win) tag = "R5";
    else if (m_cut_age >= D && m_cut_age <= D + W - 1) tag = "R7";
    else if (cl) tag = "R8";
    else tag = "R5";
    chk(m_lock ? ((m_quiet > 0) ? "R4" : "R2") : ((m_run > 0) ? "R10" : "R2"),
        "tx_disable_o", tx_disable, m_lock);
    chk(tag, "cp_en_o", cp_en, e_en);
    chk("R9", "cp_o", cp, e_en & osc);
    @(posedge clk);
    begin
      bit fall;
      bit old_lock;
      fall = m_txq && !tx;
      old_lock = m_lock;
      if (!m_lock) begin
        m_run = tx ? m_run + 1 : 0;
        if (m_run == J) begin m_lock = 1; m_run = 0; m_quiet = 0; end
      end else begin
        m_quiet = tx ? 0 : m_quiet + 1;
        if (m_quiet == U) begin m_lock = 0; m_quiet = 0; m_run = 0; end
      end
      if (fall && he && !old_lock) m_age = 0;
      else if (m_age < NONE) m_age++;
      if (fall && old_lock) m_cut_age = 0;
      else if (m_cut_age < NONE) m_cut_age++;
      m_txq = tx;
    end
  endtask

  task automatic run(input int n, input bit tx, input bit cl, input bit he);
    for (int i = 0; i < n; i++) step(tx, cl, he);
  endtask

  task automatic reset_phase(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_ni = 1'b0; tx_valid = 0; coll_det = 0; hb_en = 1; osc = 1;
      #1;
      model_reset();
      chk("R1", "tx_disable_o in reset", tx_disable, 1'b0);
      chk("R1", "cp_en_o in reset", cp_en, 1'b0);
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    model_reset();
    reset_phase(3);
    run(3, 0, 0, 1);
    // R5: short frame then heartbeat window
    run(10, 1, 0, 1);
    run(15, 0, 0, 1);
    // R10: runs one short of the limit, broken by one idle sample
    run(J - 1, 1, 0, 1);
    run(1, 0, 0, 1);
    run(J - 1, 1, 0, 1);
    run(3, 0, 0, 1);
    // R5: new frame end during the delay restarts it
    run(2, 1, 0, 1);
    run(15, 0, 0, 1);
    // R8: collision with no activity
    run(2, 0, 1, 1);
    run(1, 0, 0, 1);
    run(3, 0, 1, 1);
    // R6: strap off at the frame end, then strap dropped inside an open window
    run(8, 1, 0, 0);
    run(12, 0, 0, 0);
    run(6, 1, 0, 1);
    run(D + 1, 0, 0, 1);
    run(2, 0, 0, 0);
    run(6, 0, 0, 1);
    // R2, R3: jabber lockout with collision toggling
    run(J + 5, 1, 0, 1);
    run(4, 1, 1, 0);
    // R7: frame ends while locked, R4: quiet count broken by one active sample
    run(10, 0, 0, 1);
    run(1, 1, 0, 1);
    run(U - 1, 0, 0, 1);
    run(8, 0, 0, 1);
    run(5, 0, 0, 1);
    // R1: reset during a pending heartbeat
    run(6, 1, 0, 1);
    run(2, 0, 0, 1);
    reset_phase(2);
    run(15, 0, 0, 1);
    // lock again, reset clears it
    run(J + 2, 1, 0, 1);
    reset_phase(1);
    run(5, 0, 0, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: done actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule